// File: doc/BRIEF.md
# Redundancy-Mode Lockstep Compare and Vote Multiplexer

This block sits between up to three lockstep copies of a processor and one shared bus master port. Each copy presents a request word built from its instruction-bus and data-bus activity together with a valid strobe. A two-bit mode code tells the block how many copies currently take part and what it must do with them. In simplex it forwards copy 0 unchecked. In duplex it compares copies 0 and 1 and forwards the word only when they agree. In triplex it forwards the bitwise majority of all three, which masks one faulty copy.

A transfer goes out only when every participating copy presents valid in the same cycle. All copies are then released together through one shared ready. Three error flags stay set until reset: a duplex disagreement, a triplex case with no majority, and a loss of alignment among the copies' valid strobes. In triplex the block also latches the index of a single outvoted copy. That index stays held until a clear pulse arrives, so supervising logic can decide which region to repair.

Top module: `lockstep_vote_mux`

## Requirements
- R1: Mode code 2'b00 (simplex) and the reserved code 2'b11 forward copy 0's word with copy 0's valid alone. The valids and words of copies 1 and 2 have no effect on the output.
- R2: In mode 2'b01 (duplex), when copies 0 and 1 are both valid and carry equal words, that word is forwarded with `out_valid` high.
- R3: `out_valid` is high only in a cycle where every participating copy asserts valid. `cp_ready` is high only in such a cycle, and only when `out_ready` is high or the transfer is blocked.
- R4: In mode 2'b10 (triplex) with all three copies valid and at least two words equal, `out_data` is the bitwise majority of the three words.
- R5: A duplex transfer whose two words differ is not forwarded (`out_valid` low). It is still consumed from the copies (`cp_ready` high).
- R6: A duplex disagreement sets `err_mismatch`, which stays high until reset.
- R7: If some but not all participating copies are valid for more than SKEW_MAX (default 4) consecutive cycles, `err_desync` is set and held until reset. Exactly SKEW_MAX such cycles leave it low.
- R8: In triplex, when exactly one copy differs from the other two, `fault_valid` is set and `fault_idx` records that copy (0, 1 or 2). The first recorded index is kept until `clr_fault` is pulsed, and the pulse drops `fault_valid`.
- R9: In triplex, when all three words differ pairwise, the transfer is blocked and consumed, `err_uncorr` is set until reset, and the fault record is left unchanged.
- R10: After reset, `err_mismatch`, `err_uncorr`, `err_desync` and `fault_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Redundancy mode code |
| clr_fault | input | 1 | Clears the triplex fault record |
| cp_valid | input | 3 | Valid strobe of each copy |
| cp_data | input | 3 x DATA_W | Request word of each copy |
| cp_ready | output | 1 | Shared acceptance to all copies |
| out_valid | output | 1 | Forwarded request valid |
| out_ready | input | 1 | Bus port can accept |
| out_data | output | DATA_W | Forwarded request word |
| err_mismatch | output | 1 | Sticky duplex disagreement |
| err_uncorr | output | 1 | Sticky triplex no-majority |
| err_desync | output | 1 | Sticky valid-skew error |
| fault_valid | output | 1 | A triplex fault index is held |
| fault_idx | output | 2 | Index of the outvoted copy |

## Verification
The bench targets the reserved mode code, which a careless decoder would route to the voter or block. It checks that a duplex mismatch produces no output beat, since a design that forwarded it would let a corrupted request reach the bus. It drives a three-way disagreement to confirm the block neither forwards the bitwise majority of unrelated words nor overwrites the held fault index. It also probes the skew limit at exactly SKEW_MAX and at SKEW_MAX+1 cycles, where an off-by-one counter fires early or late, and probes the clear of the sticky fault index.

// File: rtl/lvm_pkg.sv
package lvm_pkg;

   typedef enum logic [1:0] {
      MODE_SIMPLEX = 2'b00,
      MODE_DUPLEX  = 2'b01,
      MODE_TRIPLEX = 2'b10,
      MODE_RSVD    = 2'b11
   } lvm_mode_e;

   localparam int unsigned NCOPY = 3;

   // copies that take part in a transfer for a given mode
   function automatic logic [NCOPY-1:0] part_mask(input logic [1:0] m);
      case (m)
         MODE_DUPLEX:  return 3'b011;
         MODE_TRIPLEX: return 3'b111;
         default:      return 3'b001;
      endcase
   endfunction

endpackage

// File: rtl/lvm_vote3.sv
module lvm_vote3 #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [2:0][DATA_W-1:0] d,
   output logic [DATA_W-1:0]      maj,
   output logic [2:0]             odd,
   output logic                   no_majority
);

   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_bit
         assign maj[b] = (d[0][b] & d[1][b]) | (d[0][b] & d[2][b]) | (d[1][b] & d[2][b]);
      end
   endgenerate

   genvar c;
   generate
      for (c = 0; c < 3; c++) begin : g_odd
         localparam int P = (c + 1) % 3;
         localparam int Q = (c + 2) % 3;
         assign odd[c] = (d[c] != d[P]) && (d[P] == d[Q]);
      end
   endgenerate

   assign no_majority = (d[0] != d[1]) && (d[1] != d[2]) && (d[0] != d[2]);

endmodule

// File: rtl/lvm_skew_mon.sv
module lvm_skew_mon #(
   parameter int unsigned SKEW_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic partial,
   output logic err_desync
);

   localparam int unsigned CW = $clog2(SKEW_MAX + 1);
   localparam logic [CW-1:0] LIMIT = CW'(SKEW_MAX);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q      <= '0;
         err_desync <= 1'b0;
      end else if (partial) begin
         if (run_q == LIMIT) err_desync <= 1'b1;
         else                run_q      <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   p_desync_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (partial && run_q == LIMIT) |=> err_desync);

   p_desync_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_desync |=> err_desync);

endmodule

// File: rtl/lvm_fault_log.sv
module lvm_fault_log (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_mis,
   input  logic       set_unc,
   input  logic       capture,
   input  logic [2:0] odd,
   input  logic       clr_fault,
   output logic       err_mismatch,
   output logic       err_uncorr,
   output logic       fault_valid,
   output logic [1:0] fault_idx
);

   logic [1:0] odd_idx;
   always_comb begin
      odd_idx = 2'd0;
      if (odd[1]) odd_idx = 2'd1;
      if (odd[2]) odd_idx = 2'd2;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_mismatch <= 1'b0;
         err_uncorr   <= 1'b0;
         fault_valid  <= 1'b0;
         fault_idx    <= 2'd0;
      end else begin
         if (set_mis) err_mismatch <= 1'b1;
         if (set_unc) err_uncorr   <= 1'b1;
         if (capture && (!fault_valid || clr_fault)) begin
            fault_valid <= 1'b1;
            fault_idx   <= odd_idx;
         end else if (clr_fault) begin
            fault_valid <= 1'b0;
         end
      end
   end

   p_mis_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_mismatch |=> err_mismatch);

   p_unc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_uncorr |=> err_uncorr);

   p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && !clr_fault) |=> (fault_valid && $stable(fault_idx)));

   p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_fault && !capture) |=> !fault_valid);

   p_odd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(odd));

endmodule

// File: rtl/lockstep_vote_mux.sv
module lockstep_vote_mux #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SKEW_MAX = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             mode,
   input  logic                   clr_fault,
   input  logic [2:0]             cp_valid,
   input  logic [2:0][DATA_W-1:0] cp_data,
   output logic                   cp_ready,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [DATA_W-1:0]      out_data,
   output logic                   err_mismatch,
   output logic                   err_uncorr,
   output logic                   err_desync,
   output logic                   fault_valid,
   output logic [1:0]             fault_idx
);
   import lvm_pkg::*;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("lockstep_vote_mux: DATA_W must be at least 1");
      end
      if (SKEW_MAX < 1) begin : g_bad_skew
         $error("lockstep_vote_mux: SKEW_MAX must be at least 1");
      end
   endgenerate

   logic [2:0]        mask;
   logic              all_v, any_v;
   logic [DATA_W-1:0] maj;
   logic [2:0]        odd;
   logic              no_maj;
   logic              dup_diff;
   logic              blk;
   logic [DATA_W-1:0] fwd;
   logic              is_dup, is_tmr;

   assign mask     = part_mask(mode);
   assign all_v    = &(cp_valid | ~mask);
   assign any_v    = |(cp_valid & mask);
   assign dup_diff = (cp_data[0] != cp_data[1]);
   assign is_dup   = (mode == MODE_DUPLEX);
   assign is_tmr   = (mode == MODE_TRIPLEX);

   lvm_vote3 #(.DATA_W(DATA_W)) u_vote (
      .d           (cp_data),
      .maj         (maj),
      .odd         (odd),
      .no_majority (no_maj)
   );

   always_comb begin
      blk = 1'b0;
      fwd = cp_data[0];
      if (is_dup) begin
         blk = dup_diff;
      end else if (is_tmr) begin
         blk = no_maj;
         fwd = maj;
      end
   end

   assign out_valid = all_v && !blk;
   assign out_data  = fwd;
   assign cp_ready  = all_v && (blk || out_ready);

   lvm_skew_mon #(.SKEW_MAX(SKEW_MAX)) u_skew (
      .clk        (clk),
      .rst_n      (rst_n),
      .partial    (any_v && !all_v),
      .err_desync (err_desync)
   );

   lvm_fault_log u_log (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_mis      (all_v && is_dup && dup_diff),
      .set_unc      (all_v && is_tmr && no_maj),
      .capture      (all_v && is_tmr && !no_maj && (odd != 3'b000)),
      .odd          (odd),
      .clr_fault    (clr_fault),
      .err_mismatch (err_mismatch),
      .err_uncorr   (err_uncorr),
      .fault_valid  (fault_valid),
      .fault_idx    (fault_idx)
   );

   p_all_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cp_valid[0] && (mode != MODE_DUPLEX || cp_valid[1]) &&
                     (mode != MODE_TRIPLEX || &cp_valid)));

   p_dup_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DUPLEX && &cp_valid[1:0] && cp_data[0] != cp_data[1]) |-> !out_valid);

   p_tmr_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_TRIPLEX && out_valid && cp_data[1] == cp_data[2]) |-> out_data == cp_data[1]);

   p_simplex_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SIMPLEX || mode == MODE_RSVD) |-> (out_valid == cp_valid[0] && out_data == cp_data[0]));

endmodule

// File: tb/lockstep_vote_mux_test.sv
module lockstep_vote_mux_test;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          clr_fault = 1'b0;
   logic [2:0]    cp_valid = 3'b000;
   logic [2:0][W-1:0] cp_data = '0;
   logic          cp_ready, out_valid;
   logic          out_ready = 1'b1;
   logic [W-1:0]  out_data;
   logic          err_mismatch, err_uncorr, err_desync, fault_valid;
   logic [1:0]    fault_idx;

   int n_checks = 0;
   int n_errs   = 0;

   always #10 clk = ~clk;

   lockstep_vote_mux #(.DATA_W(W), .SKEW_MAX(4)) uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .clr_fault(clr_fault),
      .cp_valid(cp_valid), .cp_data(cp_data), .cp_ready(cp_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .err_mismatch(err_mismatch), .err_uncorr(err_uncorr), .err_desync(err_desync),
      .fault_valid(fault_valid), .fault_idx(fault_idx)
   );

   typedef struct packed {
      logic [1:0]   m;
      logic [2:0]   v;
      logic         ov;
      logic [W-1:0] d0, d1, d2, ex;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{2'b00, 3'b001, 1'b1, 16'h1234, 16'h0000, 16'h0000, 16'h1234}, // R1 simplex
      '{2'b00, 3'b111, 1'b1, 16'h1234, 16'hBEEF, 16'hCAFE, 16'h1234}, // R1 others ignored
      '{2'b11, 3'b001, 1'b1, 16'hA5A5, 16'h0000, 16'hFFFF, 16'hA5A5}, // R1 reserved
      '{2'b01, 3'b011, 1'b1, 16'h55AA, 16'h55AA, 16'h0000, 16'h55AA}, // R2 duplex agree
      '{2'b01, 3'b011, 1'b0, 16'h55AA, 16'h55AB, 16'h0000, 16'h55AA}, // R5 duplex block
      '{2'b10, 3'b111, 1'b1, 16'h0F0F, 16'h0F0F, 16'h0F0F, 16'h0F0F}, // R4 all equal
      '{2'b10, 3'b111, 1'b1, 16'h0F0F, 16'hFFFF, 16'h0F0F, 16'h0F0F}, // R4 copy 1 outvoted
      '{2'b10, 3'b111, 1'b0, 16'h0001, 16'h0002, 16'h0004, 16'h0000}, // R9 no majority
      '{2'b10, 3'b011, 1'b0, 16'h7777, 16'h7777, 16'h7777, 16'h7777}, // R3 partial triplex
      '{2'b01, 3'b001, 1'b0, 16'h3333, 16'h3333, 16'h0000, 16'h3333}  // R3 partial duplex
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cp_valid = 3'b000;
      clr_fault = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      #2_000_000;
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin : main
      do_reset();
      @(negedge clk);
      chk("R10 err_mismatch", W'(err_mismatch), 0);
      chk("R10 err_uncorr",   W'(err_uncorr),   0);
      chk("R10 err_desync",   W'(err_desync),   0);
      chk("R10 fault_valid",  W'(fault_valid),  0);

      for (int i = 0; i < NV; i++) begin
         @(posedge clk); #1;
         mode = TBL[i].m; cp_valid = TBL[i].v;
         cp_data[0] = TBL[i].d0; cp_data[1] = TBL[i].d1; cp_data[2] = TBL[i].d2;
         @(negedge clk);
         chk($sformatf("R1-vector %0d out_valid (R2 R3 R4 R5)", i), W'(out_valid), W'(TBL[i].ov));
         if (TBL[i].ov) chk($sformatf("vector %0d out_data (R1 R2 R4)", i), out_data, TBL[i].ex);
      end
      @(posedge clk); #1;
      cp_valid = 3'b000;
      @(negedge clk);
      chk("R6 err_mismatch sticky", W'(err_mismatch), 1);
      chk("R9 err_uncorr sticky",   W'(err_uncorr),   1);
      chk("R8 fault_valid",         W'(fault_valid),  1);
      chk("R8 fault_idx kept over R9 case", W'(fault_idx), 1);
      chk("R7 short skews no error", W'(err_desync), 0);

      // R5: blocked duplex transfer still consumed
      mode = 2'b01; cp_valid = 3'b011; cp_data[0] = 16'h1111; cp_data[1] = 16'h2222; out_ready = 1'b0;
      #1;
      chk("R5 cp_ready on blocked", W'(cp_ready), 1);
      // R3: backpressure
      mode = 2'b10; cp_valid = 3'b111; cp_data[0] = 16'h4444; cp_data[1] = 16'h4444; cp_data[2] = 16'h4444;
      #1;
      chk("R3 out_valid under backpressure", W'(out_valid), 1);
      chk("R3 cp_ready low when out_ready low", W'(cp_ready), 0);
      out_ready = 1'b1;
      cp_valid = 3'b101;
      #1;
      chk("R3 cp_ready low on partial", W'(cp_ready), 0);
      cp_valid = 3'b000;

      // R8: clear then a new fault on copy 2
      @(posedge clk); #1;
      clr_fault = 1'b1;
      @(posedge clk); #1;
      clr_fault = 1'b0;
      @(negedge clk);
      chk("R8 clear drops fault_valid", W'(fault_valid), 0);
      @(posedge clk); #1;
      mode = 2'b10; cp_valid = 3'b111;
      cp_data[0] = 16'h9999; cp_data[1] = 16'h9999; cp_data[2] = 16'h9990;
      @(negedge clk);
      chk("R4 majority masks copy 2", out_data, 16'h9999);
      @(posedge clk); #1;
      cp_data[2] = 16'h9999; cp_data[0] = 16'h0000;
      @(posedge clk); #1;
      cp_valid = 3'b000;
      @(negedge clk);
      chk("R8 fault_idx copy 2", W'(fault_idx), 2);
      chk("R8 first fault kept", W'(fault_valid), 1);

      // R7: skew window
      do_reset();
      mode = 2'b10; cp_valid = 3'b011;
      repeat (4) @(posedge clk);
      #1; cp_valid = 3'b000;
      @(posedge clk); #1;
      chk("R7 exactly SKEW_MAX cycles", W'(err_desync), 0);
      cp_valid = 3'b110;
      repeat (5) @(posedge clk);
      #1; cp_valid = 3'b000;
      chk("R7 SKEW_MAX+1 cycles", W'(err_desync), 1);

      do_reset();
      @(negedge clk);
      chk("R10 reset clears desync", W'(err_desync), 0);
      chk("R10 reset clears fault",  W'(fault_valid), 0);

      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule